// File: doc/BRIEF.md
# Bytecode-Dispatching Return Stack

This block is a small hardware call/return stack that doubles as the dispatch engine of a bytecode interpreter. A CALL pushes a 32-bit return word. A RET normally pops the top word and presents it as the new program-counter target. When the top word is the reserved marker value 0x000001FF, the RET does not return. Instead it fetches the next byte from a byte FIFO, uses that byte to index a 256-entry lookup table, and emits a jump address together with a skip-pattern mask for an execute-with-skip stage downstream.

Because the marker can never be a useful return address, interpreter routines may nest ordinary CALL/RET pairs freely. When control falls back to the marker, the next bytecode is dispatched. In the default mode the marker stays on the stack, so every return to it dispatches again. An extended mode lets the top bit of a marker word request that the marker be consumed by the dispatch, so a bytecode handler can chain a cleanup routine behind the next handler. The block keeps a trace register holding the most recently dispatched bytecode and the FIFO position it came from.

Top module: `bcd_retstack`

## Requirements
- R1: After synchronous reset the stack is empty and the unit is idle: busy, ret_valid, underflow, disp_valid and fifo_rd are 0, and the trace outputs read 0.
- R2: call_en pushes call_word. A ret_en whose top word is not a dispatch marker pops that word and presents it on ret_addr, with ret_valid high for exactly the cycle after the accepting clock edge. Words come back in last-in, first-out order.
- R3: The stack holds 8 words. A push onto a full stack discards the oldest word, so the 8 most recent words remain poppable.
- R4: A RET on an empty stack gives ret_addr = 0 with ret_valid and underflow both high for that one cycle.
- R5: With ext_mode = 0, only a top word exactly equal to 0x000001FF is a marker. A RET on it starts a dispatch and leaves the marker in place, so a following RET dispatches again.
- R6: With ext_mode = 0, a top word whose bits [8:0] are 0x1FF but whose other bits are not all zero (for example 0x800001FF) is returned as an ordinary address.
- R7: With ext_mode = 1, a top word with bits [8:0] = 0x1FF, bits [29:9] = 0 and bit 31 set is a consuming marker. The RET pops it and dispatches, and the next RET returns the word beneath it.
- R8: With ext_mode = 1, a word with bits [8:0] = 0x1FF, bits [29:9] = 0 and bit 31 clear (bit 30 either value, e.g. 0x400001FF or 0x000001FF) dispatches without being popped. Any set bit in [29:9] makes the word an ordinary return.
- R9: A dispatch raises fifo_rd for one cycle, in the cycle after the RET edge when the FIFO is not empty. The byte read indexes the table, which is written through tbl_we/tbl_waddr/tbl_wdata. Two edges after the read, disp_valid pulses for one cycle with disp_addr = entry[9:0] and disp_skip = entry[31:10].
- R10: If the FIFO is empty during a dispatch, busy stays high with no fifo_rd and no disp_valid until fifo_empty drops. The read then happens in that same cycle, and the dispatch completes with the same timing as in R9.
- R11: At each FIFO read, trace_code captures the byte and trace_ptr captures fifo_ptr. Both hold until the next read.
- R12: While busy is high, call_en and ret_en are ignored. No ret_valid results, and the stack contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 enables consuming markers (bit 31) |
| call_en | input | 1 | Push call_word |
| call_word | input | 32 | Return word to push |
| ret_en | input | 1 | Return request |
| ret_valid | output | 1 | One-cycle strobe: ret_addr holds a popped word |
| ret_addr | output | 32 | Popped return word |
| underflow | output | 1 | RET hit an empty stack (with ret_valid) |
| busy | output | 1 | Dispatch in progress |
| fifo_empty | input | 1 | Byte FIFO has no data |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_ptr | input | PTR_W | FIFO read position of the head byte |
| fifo_rd | output | 1 | Consume the head byte this cycle |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 8 | Table write index |
| tbl_wdata | input | 32 | Table write data |
| disp_valid | output | 1 | One-cycle strobe: dispatch result valid |
| disp_addr | output | 10 | Jump address from table entry |
| disp_skip | output | 22 | Skip-pattern mask from table entry |
| trace_code | output | 8 | Last dispatched bytecode |
| trace_ptr | output | PTR_W | FIFO position of the last dispatched bytecode |

## Verification
The assertions take for granted that call_en and ret_en are never high in the same cycle, that ext_mode changes only while the unit is idle, and that fifo_data and fifo_ptr are stable and meaningful whenever fifo_empty is low. The stimulus drives one request per idle cycle and changes ext_mode only between scenarios. It presents the FIFO byte before the RET that starts a dispatch and raises fifo_empty right after the read edge, so a byte is never consumed twice. Table entries are written before any dispatch that uses them.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  // Marker value recognized in the low bits of a stack word
  localparam logic [8:0] MARK_LO = 9'h1FF;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOOK  = 2'd2
  } disp_st_t;
endpackage

// File: rtl/bcd_stack.sv
module bcd_stack #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] top_word,
  output logic              empty
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  top_idx;
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  next_idx;
  logic [IDX_W-1:0]  prev_idx;

  assign next_idx = (top_idx == LAST_IDX) ? '0 : top_idx + 1'b1;
  assign prev_idx = (top_idx == '0) ? LAST_IDX : top_idx - 1'b1;
  assign empty    = (count == '0);
  assign top_word = empty ? '0 : mem[top_idx];

  // Circular storage: a push on a full stack overwrites the oldest slot
  always_ff @(posedge clk) begin
    if (push) mem[next_idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_idx <= LAST_IDX;
      count   <= '0;
    end else if (push) begin
      top_idx <= next_idx;
      if (count != FULL_CNT) count <= count + 1'b1;
    end else if (pop && !empty) begin
      top_idx <= prev_idx;
      count   <= count - 1'b1;
    end
  end
endmodule

// File: rtl/bcd_marker.sv
module bcd_marker #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              ext_mode,
  output logic              trig,
  output logic              consume
);
  import bcd_pkg::*;

  logic low_hit;
  logic mid_zero;
  logic exact;

  assign low_hit  = (word[8:0] == MARK_LO);
  assign mid_zero = (word[WORD_W-3:9] == '0);
  assign exact    = low_hit && mid_zero && (word[WORD_W-1:WORD_W-2] == 2'b00);

  always_comb begin
    if (ext_mode) begin
      trig    = low_hit && mid_zero;
      consume = low_hit && mid_zero && word[WORD_W-1];
    end else begin
      trig    = exact;
      consume = 1'b0;
    end
  end
endmodule

// File: rtl/bcd_table.sv
module bcd_table #(
  parameter int IDX_W   = 8,
  parameter int ENTRY_W = 32
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               re,
  input  logic [IDX_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bcd_retstack.sv
module bcd_retstack #(
  parameter int DEPTH   = 8,
  parameter int WORD_W  = 32,
  parameter int CODE_W  = 8,
  parameter int ENTRY_W = 32,
  parameter int JMP_W   = 10,
  parameter int PTR_W   = 8,
  localparam int SKIP_W = ENTRY_W - JMP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_mode,
  input  logic               call_en,
  input  logic [WORD_W-1:0]  call_word,
  input  logic               ret_en,
  output logic               ret_valid,
  output logic [WORD_W-1:0]  ret_addr,
  output logic               underflow,
  output logic               busy,
  input  logic               fifo_empty,
  input  logic [CODE_W-1:0]  fifo_data,
  input  logic [PTR_W-1:0]   fifo_ptr,
  output logic               fifo_rd,
  input  logic               tbl_we,
  input  logic [CODE_W-1:0]  tbl_waddr,
  input  logic [ENTRY_W-1:0] tbl_wdata,
  output logic               disp_valid,
  output logic [JMP_W-1:0]   disp_addr,
  output logic [SKIP_W-1:0]  disp_skip,
  output logic [CODE_W-1:0]  trace_code,
  output logic [PTR_W-1:0]   trace_ptr
);
  import bcd_pkg::*;

  disp_st_t           state;
  logic               idle;
  logic               call_acc;
  logic               ret_acc;
  logic               trig;
  logic               consume;
  logic               do_pop;
  logic               stk_empty;
  logic [WORD_W-1:0]  top_word;
  logic [ENTRY_W-1:0] tbl_rdata;

  assign idle     = (state == ST_IDLE);
  assign call_acc = idle && call_en;
  assign ret_acc  = idle && ret_en && !call_en;
  assign do_pop   = ret_acc && (!trig || consume);
  assign busy     = !idle;
  assign fifo_rd  = (state == ST_FETCH) && !fifo_empty;

  bcd_stack #(
    .DEPTH (DEPTH),
    .WORD_W(WORD_W)
  ) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (call_acc),
    .pop     (do_pop),
    .din     (call_word),
    .top_word(top_word),
    .empty   (stk_empty)
  );

  bcd_marker #(
    .WORD_W(WORD_W)
  ) u_marker (
    .word    (top_word),
    .ext_mode(ext_mode),
    .trig    (trig),
    .consume (consume)
  );

  bcd_table #(
    .IDX_W  (CODE_W),
    .ENTRY_W(ENTRY_W)
  ) u_table (
    .clk  (clk),
    .we   (tbl_we),
    .waddr(tbl_waddr),
    .wdata(tbl_wdata),
    .re   (fifo_rd),
    .raddr(fifo_data),
    .rdata(tbl_rdata)
  );

  // Dispatch sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (ret_acc && trig) state <= ST_FETCH;
        ST_FETCH: if (!fifo_empty)     state <= ST_LOOK;
        ST_LOOK:                       state <= ST_IDLE;
        default:                       state <= ST_IDLE;
      endcase
    end
  end

  // Return path outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 1'b0;
      ret_addr  <= '0;
      underflow <= 1'b0;
    end else begin
      ret_valid <= ret_acc && !trig;
      underflow <= ret_acc && !trig && stk_empty;
      if (ret_acc && !trig) ret_addr <= top_word;
    end
  end

  // Dispatch outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_addr  <= '0;
      disp_skip  <= '0;
    end else begin
      disp_valid <= (state == ST_LOOK);
      if (state == ST_LOOK) begin
        disp_addr <= tbl_rdata[JMP_W-1:0];
        disp_skip <= tbl_rdata[ENTRY_W-1:JMP_W];
      end
    end
  end

  // Trace of the most recent bytecode
  always_ff @(posedge clk) begin
    if (rst) begin
      trace_code <= '0;
      trace_ptr  <= '0;
    end else if (fifo_rd) begin
      trace_code <= fifo_data;
      trace_ptr  <= fifo_ptr;
    end
  end
endmodule

// File: rtl/bcd_retstack_chk.sv
module bcd_retstack_chk #(
  parameter int WORD_W  = 32,
  parameter int CODE_W  = 8,
  parameter int ENTRY_W = 32,
  parameter int JMP_W   = 10,
  parameter int PTR_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                ext_mode,
  input logic                call_en,
  input logic [WORD_W-1:0]   call_word,
  input logic                ret_en,
  input logic                ret_valid,
  input logic [WORD_W-1:0]   ret_addr,
  input logic                underflow,
  input logic                busy,
  input logic                fifo_empty,
  input logic [CODE_W-1:0]   fifo_data,
  input logic [PTR_W-1:0]    fifo_ptr,
  input logic                fifo_rd,
  input logic                tbl_we,
  input logic [CODE_W-1:0]   tbl_waddr,
  input logic [ENTRY_W-1:0]  tbl_wdata,
  input logic                disp_valid,
  input logic [JMP_W-1:0]    disp_addr,
  input logic [ENTRY_W-JMP_W-1:0] disp_skip,
  input logic [CODE_W-1:0]   trace_code,
  input logic [PTR_W-1:0]    trace_ptr
);
  // R4: an underflow return always reports a zero address
  p_underflow_zero_r4: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (ret_valid && ret_addr == '0));

  // R2: a return strobe lasts one cycle unless another return was accepted
  p_ret_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    (!ret_en) |=> !ret_valid);

  // R9: a read is followed two edges later by a dispatch strobe
  p_disp_after_read_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |=> ##1 disp_valid);

  // R9: dispatch strobe is a single-cycle pulse
  p_disp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid);

  // R10: no read from an empty FIFO, and reads only during a dispatch
  p_no_empty_read_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (!fifo_empty && busy));

  // R11: trace captures the byte and pointer presented at the read
  p_trace_capture_r11: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |=> (trace_code == $past(fifo_data) && trace_ptr == $past(fifo_ptr)));

  // R12: requests during a dispatch give no return strobe
  p_busy_ignores_ret_r12: assert property (@(posedge clk) disable iff (rst)
    busy |=> !ret_valid);

  // R9: return and dispatch strobes never coincide
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ret_valid, disp_valid}));
endmodule

bind bcd_retstack bcd_retstack_chk #(
  .WORD_W (WORD_W),
  .CODE_W (CODE_W),
  .ENTRY_W(ENTRY_W),
  .JMP_W  (JMP_W),
  .PTR_W  (PTR_W)
) u_chk (.*);

// File: tb/sim_bcd_retstack.sv
`timescale 1ns/1ps
module sim_bcd_retstack;
  logic        clk = 1'b0;
  logic        rst;
  logic        ext_mode;
  logic        call_en;
  logic [31:0] call_word;
  logic        ret_en;
  logic        ret_valid;
  logic [31:0] ret_addr;
  logic        underflow;
  logic        busy;
  logic        fifo_empty;
  logic [7:0]  fifo_data;
  logic [7:0]  fifo_ptr;
  logic        fifo_rd;
  logic        tbl_we;
  logic [7:0]  tbl_waddr;
  logic [31:0] tbl_wdata;
  logic        disp_valid;
  logic [9:0]  disp_addr;
  logic [21:0] disp_skip;
  logic [7:0]  trace_code;
  logic [7:0]  trace_ptr;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bcd_retstack u0 (
    .clk(clk), .rst(rst), .ext_mode(ext_mode),
    .call_en(call_en), .call_word(call_word), .ret_en(ret_en),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .underflow(underflow),
    .busy(busy), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_ptr(fifo_ptr), .fifo_rd(fifo_rd), .tbl_we(tbl_we),
    .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata), .disp_valid(disp_valid),
    .disp_addr(disp_addr), .disp_skip(disp_skip),
    .trace_code(trace_code), .trace_ptr(trace_ptr)
  );

  function automatic logic [31:0] entry_of(input logic [7:0] b);
    return {b ^ 8'h5A, ~b, b + 8'd3, b};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Advance one edge and settle away from it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic do_call(input logic [31:0] w);
    call_en = 1'b1;
    call_word = w;
    tick();
    call_en = 1'b0;
  endtask

  task automatic do_ret();
    ret_en = 1'b1;
    tick();
    ret_en = 1'b0;
  endtask

  task automatic expect_ret(input string tag, input logic [31:0] a, input logic uf);
    do_ret();
    chk({tag, " ret_valid"}, ret_valid, 1);
    chk({tag, " ret_addr"}, ret_addr, a);
    chk({tag, " underflow"}, underflow, uf);
  endtask

  // Called right after a RET edge that started a dispatch with a byte waiting
  task automatic expect_dispatch(input string tag, input logic [7:0] b, input logic [7:0] p);
    logic [31:0] e;
    e = entry_of(b);
    chk({tag, " no ret_valid"}, ret_valid, 0);
    chk({tag, " busy"}, busy, 1);
    chk({tag, " fifo_rd"}, fifo_rd, 1);
    tick();
    fifo_empty = 1'b1;
    chk({tag, " fifo_rd once"}, fifo_rd, 0);
    chk({tag, " not yet valid"}, disp_valid, 0);
    chk({tag, " R11 trace_code"}, trace_code, b);
    chk({tag, " R11 trace_ptr"}, trace_ptr, p);
    tick();
    chk({tag, " disp_valid"}, disp_valid, 1);
    chk({tag, " disp_addr"}, disp_addr, e[9:0]);
    chk({tag, " disp_skip"}, disp_skip, e[31:10]);
    tick();
    chk({tag, " pulse end"}, disp_valid, 0);
    chk({tag, " idle"}, busy, 0);
  endtask

  task automatic offer(input logic [7:0] b, input logic [7:0] p);
    fifo_empty = 1'b0;
    fifo_data = b;
    fifo_ptr = p;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy", busy, 0);
    chk("R1 ret_valid", ret_valid, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 disp_valid", disp_valid, 0);
    chk("R1 fifo_rd", fifo_rd, 0);
    chk("R1 trace", {trace_code, trace_ptr}, 0);
    expect_ret("R1 empty after reset", 32'h0, 1'b1);
  endtask

  task automatic t_lifo();
    do_reset();
    ext_mode = 1'b0;
    do_call(32'h0000_1000);
    do_call(32'hDEAD_0004);
    do_call(32'h0000_0ABC);
    expect_ret("R2 lifo 1", 32'h0000_0ABC, 1'b0);
    tick();
    chk("R2 strobe one cycle", ret_valid, 0);
    expect_ret("R2 lifo 2", 32'hDEAD_0004, 1'b0);
    expect_ret("R2 lifo 3", 32'h0000_1000, 1'b0);
    expect_ret("R4 underflow", 32'h0, 1'b1);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 9; i++) do_call(32'h100 + i);
    for (int i = 8; i >= 1; i--) expect_ret("R3 keep newest", 32'h100 + i, 1'b0);
    expect_ret("R3 oldest dropped", 32'h0, 1'b1);
  endtask

  task automatic t_default_marker();
    do_reset();
    ext_mode = 1'b0;
    do_call(32'h0000_1234);
    do_call(32'h0000_01FF);
    offer(8'h05, 8'h21);
    do_ret();
    expect_dispatch("R5 R9 first", 8'h05, 8'h21);
    offer(8'h06, 8'h22);
    do_ret();
    expect_dispatch("R5 marker kept", 8'h06, 8'h22);
  endtask

  task automatic t_default_plain();
    do_reset();
    ext_mode = 1'b0;
    do_call(32'h0000_0040);
    do_call(32'h8000_01FF);
    offer(8'h07, 8'h30);
    expect_ret("R6 high bit plain", 32'h8000_01FF, 1'b0);
    chk("R6 no read", fifo_rd, 0);
    expect_ret("R6 beneath", 32'h0000_0040, 1'b0);
    fifo_empty = 1'b1;
  endtask

  task automatic t_ext_consume();
    do_reset();
    ext_mode = 1'b1;
    do_call(32'h0000_0ABC);
    do_call(32'h8000_01FF);
    offer(8'h0A, 8'h41);
    do_ret();
    expect_dispatch("R7 consume", 8'h0A, 8'h41);
    expect_ret("R7 popped marker", 32'h0000_0ABC, 1'b0);
    ext_mode = 1'b0;
  endtask

  task automatic t_ext_keep();
    do_reset();
    ext_mode = 1'b1;
    do_call(32'h0000_0055);
    do_call(32'h4000_01FF);
    offer(8'h0B, 8'h50);
    do_ret();
    expect_dispatch("R8 bit30 first", 8'h0B, 8'h50);
    offer(8'h0C, 8'h51);
    do_ret();
    expect_dispatch("R8 bit30 kept", 8'h0C, 8'h51);
    do_reset();
    do_call(32'h0000_01FF);
    offer(8'h0D, 8'h52);
    do_ret();
    expect_dispatch("R8 plain marker", 8'h0D, 8'h52);
    do_reset();
    do_call(32'h0020_01FF);
    offer(8'h0E, 8'h53);
    expect_ret("R8 mid bit plain", 32'h0020_01FF, 1'b0);
    fifo_empty = 1'b1;
    ext_mode = 1'b0;
  endtask

  task automatic t_stall();
    do_reset();
    ext_mode = 1'b0;
    fifo_empty = 1'b1;
    do_call(32'h0000_01FF);
    do_ret();
    for (int i = 0; i < 3; i++) begin
      chk("R10 busy", busy, 1);
      chk("R10 no read", fifo_rd, 0);
      chk("R10 no disp", disp_valid, 0);
      tick();
    end
    do_ret();
    chk("R12 ret ignored", ret_valid, 0);
    do_call(32'h0000_0077);
    chk("R10 still busy", busy, 1);
    offer(8'h0F, 8'h60);
    #0;
    expect_dispatch("R10 after stall", 8'h0F, 8'h60);
    offer(8'h03, 8'h61);
    do_ret();
    expect_dispatch("R12 call ignored", 8'h03, 8'h61);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; ext_mode = 1'b0; call_en = 1'b0; call_word = '0; ret_en = 1'b0;
    fifo_empty = 1'b1; fifo_data = '0; fifo_ptr = '0;
    tbl_we = 1'b0; tbl_waddr = '0; tbl_wdata = '0;
    #1;
    for (int b = 0; b < 16; b++) begin
      tbl_we = 1'b1;
      tbl_waddr = 8'(b);
      tbl_wdata = entry_of(8'(b));
      tick();
    end
    tbl_we = 1'b0;
    t_reset();
    t_lifo();
    t_overflow();
    t_default_marker();
    t_default_plain();
    t_ext_consume();
    t_ext_keep();
    t_stall();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule